// File: doc/BRIEF.md
# Ingress Packet Priority Classifier

This block sits on the receive side of one switch port. It watches the first sixteen bytes of each arriving frame on a byte-wide stream and assigns the frame a 3-bit receive priority, where 0 is the lowest and 7 the highest. Bytes 12 and 13 carry the length/type field, most significant byte first. The block checks that field and the byte after it in a fixed order. A frame whose type matches a configurable tag type takes the tag's priority bits. An IPv4 or IPv6 frame whose version nibble is correct, and whose protocol enable is set, takes its 6-bit code point through a 64-entry code-point table. Any other frame takes the port's default priority.

The receive priority then passes through an 8-entry receive map to give the header priority. The header priority is the priority the switch uses internally, and it is also the value placed in an outgoing VLAN tag. Software loads the code-point table through a single-entry write port. The block produces one result per frame as a single-cycle strobe. The priority outputs keep their last values between strobes.

Top module: `rx_prio_classifier`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0 and both priority outputs are 0. Every code-point table entry resets to 0.
- R2: If bytes 12..13 equal `cfg_vlan_type`, the receive priority is bits 7:5 of byte 14. This check comes before every other rule.
- R3: If the type is 0x0800, bits 7:4 of byte 14 equal 4 and `cfg_v4_en` is 1, the receive priority is the table entry at bits 7:2 of byte 15.
- R4: If the type is 0x86DD, bits 7:4 of byte 14 equal 6 and `cfg_v6_en` is 1, the receive priority is the table entry at the code point {byte14[3:0], byte15[7:6]}.
- R5: If none of R2..R4 applies, the receive priority is `cfg_port_prio`. This includes a wrong version nibble and a cleared enable.
- R6: The header priority is entry r of `cfg_rx_map`, where r is the receive priority and entry r sits at bits 3r+2:3r.
- R7: `res_valid` is high for exactly one cycle, the cycle after byte 15 of a frame is accepted. Each frame gives at most one result. Later bytes of the frame have no effect, and the priority outputs hold their values between strobes.
- R8: A frame that ends (`fr_eof` with `fr_valid`) before byte 15 gives its result the cycle after its last byte, with the receive priority set to `cfg_port_prio`.
- R9: A byte counts only when `fr_valid` is 1. `fr_sof` marks byte 0 and discards any partial frame. Valid bytes that arrive after an end and before the next start are ignored.
- R10: When `dscp_wr_en` is 1 at a clock edge, table entry `dscp_wr_addr` takes `dscp_wr_data`. Frames classified at later edges use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_valid | input | 1 | Stream byte valid |
| fr_sof | input | 1 | First byte of a frame |
| fr_eof | input | 1 | Last byte of a frame |
| fr_data | input | 8 | Stream byte |
| cfg_vlan_type | input | 16 | Type value that marks a tagged frame |
| cfg_v4_en | input | 1 | Enable IPv4 code-point classification |
| cfg_v6_en | input | 1 | Enable IPv6 traffic-class classification |
| cfg_port_prio | input | 3 | Port default priority |
| cfg_rx_map | input | 24 | Receive priority to header priority map, 8 x 3 bits |
| dscp_wr_en | input | 1 | Code-point table write strobe |
| dscp_wr_addr | input | 6 | Table entry to write |
| dscp_wr_data | input | 3 | Priority to store |
| res_valid | output | 1 | Result strobe, one cycle per frame |
| res_rx_prio | output | 3 | Receive priority |
| res_hdr_prio | output | 3 | Header priority |

## Verification
The classification result is registered exactly once. It is due at the first clock edge after the frame's byte 15 is accepted, or after its end byte if the frame is shorter than sixteen bytes. Any idle cycles with `fr_valid` low push that edge back by the same number of cycles. The bench's model consumes each byte at the same rising edge as the design and updates its expected strobe and priorities there. The comparison runs at the following falling edge, so every cycle is checked against the value due in it. Table writes take effect in the model after the classification of that same edge, which matches the one-edge delay given in R10.

// File: rtl/rxpc_pkg.sv
// Package rxpc_pkg
// Shared sizes, frame offsets and protocol constants for the ingress
// priority classifier. Assumes an untagged Ethernet header layout with
// the type field at bytes 12..13.
package rxpc_pkg;
    localparam int PRIO_W = 3;
    localparam int NPRIO  = 1 << PRIO_W;
    localparam int CODE_W = 6;
    localparam int NCODE  = 1 << CODE_W;
    localparam int BYTE_W = 8;
    localparam int TYPE_W = 2 * BYTE_W;
    localparam int CNT_W  = 5;

    localparam logic [CNT_W-1:0] IDX_TYPE_HI = 5'd12;
    localparam logic [CNT_W-1:0] IDX_TYPE_LO = 5'd13;
    localparam logic [CNT_W-1:0] IDX_B14     = 5'd14;
    localparam logic [CNT_W-1:0] IDX_LAST    = 5'd15;
    localparam logic [CNT_W-1:0] IDX_SAT     = 5'd16;

    localparam logic [TYPE_W-1:0] ETH_IPV4 = 16'h0800;
    localparam logic [TYPE_W-1:0] ETH_IPV6 = 16'h86DD;
    localparam logic [3:0]        VER_4    = 4'h4;
    localparam logic [3:0]        VER_6    = 4'h6;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxpc_capture.sv
// Module rxpc_capture
// Counts the bytes of the current frame and latches the type field and
// byte 14. Raises `fire` once per frame: on byte 15, or on an end byte
// that comes earlier. Assumes fr_sof is only meaningful together with
// fr_valid.
module rxpc_capture
    import rxpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              valid,
    input  logic              eof,
    input  byte_t             data,
    output logic              fire,
    output logic              full,
    output logic [TYPE_W-1:0] type_q,
    output byte_t             b14_q
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic             active;
    logic             done;
    logic             acc;

    // index of the byte on the wire this cycle and whether it belongs to a frame
    always_comb begin
        idx  = sof ? '0 : cnt;
        acc  = valid & (sof | active);
        full = acc & (idx == IDX_LAST);
        fire = acc & (sof | ~done) & (full | eof);
    end

    // byte counter, frame state and field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
            done   <= 1'b0;
            type_q <= '0;
            b14_q  <= '0;
        end else if (acc) begin
            if (idx != IDX_SAT) cnt <= idx + 1'b1;
            active <= ~eof;
            if (fire)     done <= 1'b1;
            else if (sof) done <= 1'b0;
            if (idx == IDX_TYPE_HI) type_q[TYPE_W-1:BYTE_W] <= data;
            if (idx == IDX_TYPE_LO) type_q[BYTE_W-1:0]      <= data;
            if (idx == IDX_B14)     b14_q                   <= data;
        end
    end
endmodule

// File: rtl/rxpc_dscp_table.sv
// Module rxpc_dscp_table
// Code-point to priority table with one synchronous write port and one
// asynchronous read port. A write becomes visible to reads after the
// edge that performs it.
module rxpc_dscp_table
    import rxpc_pkg::*;
#(
    parameter int ENTRIES = NCODE
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  code_t wr_addr,
    input  prio_t wr_data,
    input  code_t rd_addr,
    output prio_t rd_data
);
    prio_t tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // one table entry, cleared on reset and loaded by a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl[g] <= '0;
            else if (wr_en && wr_addr == code_t'(g))
                tbl[g] <= wr_data;
        end
    end

    // read the addressed entry
    always_comb rd_data = tbl[rd_addr];
endmodule

// File: rtl/rxpc_decide.sv
// Module rxpc_decide
// Combinational selection of the receive priority in fixed precedence
// (tag, IPv4, IPv6, port default) followed by the receive map lookup.
// Assumes b15 is the byte on the wire when `full` is high.
module rxpc_decide
    import rxpc_pkg::*;
(
    input  logic               full,
    input  logic [TYPE_W-1:0]  type_q,
    input  byte_t              b14,
    input  byte_t              b15,
    input  logic [TYPE_W-1:0]  cfg_vlan_type,
    input  logic               cfg_v4_en,
    input  logic               cfg_v6_en,
    input  prio_t              cfg_port_prio,
    input  logic [NPRIO*PRIO_W-1:0] cfg_rx_map,
    output code_t              tbl_addr,
    input  prio_t              tbl_data,
    output prio_t              rx_prio,
    output prio_t              hdr_prio
);
    logic is_tag, is_v4, is_v6;
    logic unused_b15;

    // the two low bits of byte 15 never take part in a code point
    always_comb unused_b15 = ^b15[1:0];

    // protocol detection and code-point extraction
    always_comb begin
        is_tag   = full && (type_q == cfg_vlan_type);
        is_v4    = full && cfg_v4_en && (type_q == ETH_IPV4) && (b14[7:4] == VER_4);
        is_v6    = full && cfg_v6_en && (type_q == ETH_IPV6) && (b14[7:4] == VER_6);
        tbl_addr = (type_q == ETH_IPV6) ? {b14[3:0], b15[7:6]} : b15[7:2];
    end

    // precedence chain and receive map
    always_comb begin
        if (is_tag)                rx_prio = b14[7:5];
        else if (is_v4 || is_v6)   rx_prio = tbl_data;
        else                       rx_prio = cfg_port_prio;
        hdr_prio = cfg_rx_map[int'(rx_prio)*PRIO_W +: PRIO_W];
    end
endmodule

// File: rtl/rx_prio_classifier.sv
// Module rx_prio_classifier
// Top level of the per-port ingress priority classifier. Registers one
// result per frame. Assumes the configuration stays stable while a frame
// is being classified.
module rx_prio_classifier
    import rxpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fr_valid,
    input  logic        fr_sof,
    input  logic        fr_eof,
    input  logic [7:0]  fr_data,
    input  logic [15:0] cfg_vlan_type,
    input  logic        cfg_v4_en,
    input  logic        cfg_v6_en,
    input  logic [2:0]  cfg_port_prio,
    input  logic [23:0] cfg_rx_map,
    input  logic        dscp_wr_en,
    input  logic [5:0]  dscp_wr_addr,
    input  logic [2:0]  dscp_wr_data,
    output logic        res_valid,
    output logic [2:0]  res_rx_prio,
    output logic [2:0]  res_hdr_prio
);
    logic              fire, full;
    logic [TYPE_W-1:0] type_q;
    byte_t             b14_q;
    code_t             tbl_addr;
    prio_t             tbl_data, rx_c, hdr_c;

    rxpc_capture u_cap (
        .clk(clk), .rst_n(rst_n), .sof(fr_sof), .valid(fr_valid), .eof(fr_eof),
        .data(fr_data), .fire(fire), .full(full), .type_q(type_q), .b14_q(b14_q)
    );

    rxpc_dscp_table #(.ENTRIES(NCODE)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(dscp_wr_en), .wr_addr(dscp_wr_addr),
        .wr_data(dscp_wr_data), .rd_addr(tbl_addr), .rd_data(tbl_data)
    );

    rxpc_decide u_dec (
        .full(full), .type_q(type_q), .b14(b14_q), .b15(fr_data),
        .cfg_vlan_type(cfg_vlan_type), .cfg_v4_en(cfg_v4_en), .cfg_v6_en(cfg_v6_en),
        .cfg_port_prio(cfg_port_prio), .cfg_rx_map(cfg_rx_map),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .rx_prio(rx_c), .hdr_prio(hdr_c)
    );

    // result register: strobe per frame, priorities held between strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_rx_prio  <= '0;
            res_hdr_prio <= '0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                res_rx_prio  <= rx_c;
                res_hdr_prio <= hdr_c;
            end
        end
    end
endmodule

// File: rtl/rxpc_checker.sv
// Module rxpc_checker
// Port-level properties of rx_prio_classifier, bound to every instance.
module rxpc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        fr_valid,
    input logic        fr_sof,
    input logic        fr_eof,
    input logic [2:0]  cfg_port_prio,
    input logic [23:0] cfg_rx_map,
    input logic        res_valid,
    input logic [2:0]  res_rx_prio,
    input logic [2:0]  res_hdr_prio
);
    // R1: an edge taken in reset leaves no strobe
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !res_valid);

    // R6: header priority follows the receive map seen at the deciding edge
    p_map_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_hdr_prio == 3'($past(cfg_rx_map) >> (3 * int'(res_rx_prio))));

    // R7: a result is only due right after an accepted byte
    p_strobe_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(fr_valid));

    // R7: outputs hold between strobes
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_rx_prio) && $stable(res_hdr_prio)));

    // R8: a one-byte frame gives the port default
    p_tiny_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(fr_valid && fr_sof && fr_eof)) |-> res_rx_prio == $past(cfg_port_prio));
endmodule

bind rx_prio_classifier rxpc_checker u_chk (.*);

// File: tb/sim_rx_prio_classifier.sv
module sim_rx_prio_classifier;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fr_valid = 0, fr_sof = 0, fr_eof = 0;
    logic [7:0]  fr_data = 0;
    logic [15:0] cfg_vlan_type = 16'h8100;
    logic        cfg_v4_en = 1, cfg_v6_en = 1;
    logic [2:0]  cfg_port_prio = 3'd2;
    logic [23:0] cfg_rx_map;
    logic        dscp_wr_en = 0;
    logic [5:0]  dscp_wr_addr = 0;
    logic [2:0]  dscp_wr_data = 0;
    logic        res_valid;
    logic [2:0]  res_rx_prio, res_hdr_prio;

    int checks = 0, errors = 0;
    bit finished = 0;
    string scen = "R1";

    always #(PERIOD/2) clk = ~clk;

    rx_prio_classifier u0 (.*);

    // ---------------- behavioural reference model ----------------
    logic [7:0] mq[$];
    bit   m_act, m_done;
    int   mtab[64];
    int   exp_v, exp_rx, exp_hdr;
    string exp_tag = "R1";

    task automatic classify();
        int rx; logic [15:0] typ;
        if (mq.size() < 16) begin rx = cfg_port_prio; exp_tag = "R8"; end
        else begin
            typ = {mq[12], mq[13]};
            if (typ == cfg_vlan_type) begin rx = mq[14] >> 5; exp_tag = "R2"; end
            else if (typ == 16'h0800 && mq[14][7:4] == 4'h4 && cfg_v4_en) begin
                rx = mtab[mq[15] >> 2]; exp_tag = "R3";
            end else if (typ == 16'h86DD && mq[14][7:4] == 4'h6 && cfg_v6_en) begin
                rx = mtab[((mq[14] & 8'hF) << 2) | (mq[15] >> 6)]; exp_tag = "R4";
            end else begin rx = cfg_port_prio; exp_tag = "R5"; end
        end
        exp_rx  = rx;
        exp_hdr = (cfg_rx_map >> (3 * rx)) & 7;
        exp_v   = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq = {}; m_act = 0; m_done = 0; exp_v = 0; exp_rx = 0; exp_hdr = 0;
            foreach (mtab[i]) mtab[i] = 0;
        end else begin
            exp_v = 0;
            if (fr_valid) begin
                if (fr_sof) begin mq = {}; m_act = 1; m_done = 0; end
                if (m_act) begin
                    mq.push_back(fr_data);
                    if (!m_done && (mq.size() == 16 || fr_eof)) begin
                        classify(); m_done = 1;
                    end
                    if (fr_eof) m_act = 0;
                end
            end
            if (dscp_wr_en) mtab[dscp_wr_addr] = dscp_wr_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual %0d expected %0d", tag, scen, $time, act, expv);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(res_valid == exp_v[0], "R7 strobe", res_valid, exp_v);
            if (exp_v != 0) begin
                chk(res_rx_prio == exp_rx[2:0], {exp_tag, " rx"}, res_rx_prio, exp_rx);
                chk(res_hdr_prio == exp_hdr[2:0], "R6 hdr", res_hdr_prio, exp_hdr);
            end else begin
                chk(res_rx_prio == exp_rx[2:0], "R7 hold rx", res_rx_prio, exp_rx);
                chk(res_hdr_prio == exp_hdr[2:0], "R7 hold hdr", res_hdr_prio, exp_hdr);
            end
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] fr[$];

    task automatic mk(input logic [15:0] typ, input logic [7:0] b14, input logic [7:0] b15, input int len);
        fr = {};
        for (int i = 0; i < len; i++) begin
            if (i == 12)      fr.push_back(typ[15:8]);
            else if (i == 13) fr.push_back(typ[7:0]);
            else if (i == 14) fr.push_back(b14);
            else if (i == 15) fr.push_back(b15);
            else              fr.push_back(8'(i) ^ 8'h5A);
        end
    endtask

    task automatic send(input bit gap, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fr_valid = 1; fr_sof = (i == 0); fr_eof = (i == n - 1) && (n == fr.size());
            fr_data = fr[i];
            if (gap && (i % 3 == 1)) begin
                @(negedge clk); fr_valid = 0; fr_sof = 0; fr_eof = 0;
            end
        end
        @(negedge clk); fr_valid = 0; fr_sof = 0; fr_eof = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_tbl(input int a, input int d);
        @(negedge clk); dscp_wr_en = 1; dscp_wr_addr = 6'(a); dscp_wr_data = 3'(d);
        @(negedge clk); dscp_wr_en = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) cfg_rx_map[3*i +: 3] = 3'(i ^ 3);
        repeat (3) @(negedge clk);
        scen = "R1 reset";
        chk(res_valid == 0, "R1", res_valid, 0);
        chk(res_rx_prio == 0, "R1", res_rx_prio, 0);
        chk(res_hdr_prio == 0, "R1", res_hdr_prio, 0);
        rst_n = 1;
        @(negedge clk);
        scen = "R1 table cleared";
        mk(16'h0800, 8'h45, 8'hB8, 20); send(0, 20);

        scen = "R10 table load";
        for (int i = 0; i < 64; i++) wr_tbl(i, (i * 5 + 3) & 7);

        scen = "R2 tagged";         mk(16'h8100, 8'hA0, 8'h11, 30); send(0, 30);
        scen = "R2 priority tag";   mk(16'h8100, 8'hE0, 8'h00, 16); send(0, 16);
        scen = "R3 ipv4";           mk(16'h0800, 8'h45, 8'hB8, 40); send(0, 40);
        scen = "R3 ipv4 gaps";      mk(16'h0800, 8'h45, 8'h28, 24); send(1, 24);
        scen = "R5 ipv4 bad ver";   mk(16'h0800, 8'h65, 8'hB8, 20); send(0, 20);
        cfg_v4_en = 0;
        scen = "R5 ipv4 disabled";  mk(16'h0800, 8'h45, 8'hB8, 20); send(0, 20);
        cfg_v4_en = 1;
        scen = "R4 ipv6";           mk(16'h86DD, 8'h6B, 8'h80, 40); send(0, 40);
        scen = "R4 ipv6 gaps";      mk(16'h86DD, 8'h61, 8'hC0, 18); send(1, 18);
        scen = "R5 ipv6 bad ver";   mk(16'h86DD, 8'h4B, 8'h80, 20); send(0, 20);
        cfg_v6_en = 0;
        scen = "R5 ipv6 disabled";  mk(16'h86DD, 8'h6B, 8'h80, 20); send(0, 20);
        cfg_v6_en = 1;
        cfg_port_prio = 3'd6;
        scen = "R5 other type";     mk(16'h0806, 8'h45, 8'hB8, 20); send(0, 20);
        cfg_vlan_type = 16'h0800;
        scen = "R2 precedence";     mk(16'h0800, 8'h45, 8'hB8, 20); send(0, 20);
        cfg_vlan_type = 16'h88A8;
        scen = "R8 short";          mk(16'h0800, 8'h45, 8'hB8, 10); send(0, 10);
        scen = "R8 fifteen bytes";  mk(16'h8100, 8'hE0, 8'h00, 15); send(0, 15);
        scen = "R8 one byte";       mk(16'h0800, 8'h45, 8'hB8, 1);  send(0, 1);
        scen = "R7 exactly sixteen"; mk(16'h0800, 8'h45, 8'hFC, 16); send(0, 16);
        scen = "R9 restart";        mk(16'h88A8, 8'h20, 8'h00, 30); send(0, 9);
        mk(16'h0800, 8'h45, 8'h44, 20); send(0, 20);
        scen = "R9 stray bytes";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); fr_valid = 1; fr_data = (i == 13) ? 8'h00 : 8'h08;
        end
        @(negedge clk); fr_valid = 0;
        repeat (3) @(negedge clk);
        scen = "R10 rewrite";
        wr_tbl(46, 1);
        mk(16'h0800, 8'h45, 8'hB8, 20); send(0, 20);
        cfg_rx_map = 24'hFAC688;
        scen = "R6 new map";        mk(16'h88A8, 8'h60, 8'h00, 20); send(1, 20);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R7 actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule